// File: doc/BRIEF.md
# Linear CCD Line Timing Generator

This block derives every pixel-rate and line-rate strobe that a three-colour linear CCD readout chain needs from one master clock. One pixel period is ten master cycles. Within each pixel it drives a pair of complementary horizontal shift clocks. Within each readout group it places the output-node reset pulse, the clamp and sample strobes for correlated double sampling, a converter clock and a pixel-valid strobe. A readout group is one pixel, or two or four pixels when charge binning is selected. At line rate it marks the start of each line, flags the video region and issues the two transfer-gate pulses and a frame sync. These go out only on every N-th line, where N is the chosen integration multiple. Two exposure gates, one for red and one for green, stay high for a programmable number of pixels at the start of each line.

The mode inputs are line length, binning, integration multiple and the two exposure settings. All of them are captured together at a line boundary, and also while reset is held, so no line ever mixes two timings. Every output is registered. Each output shows the counter state of the previous master cycle.

Top module: `ccd_line_timer`

## Requirements
- R1: While `rst` is high, all outputs are low on the next clock. The first clock after release produces pixel 0, phase 0 of a transfer line.
- R2: A pixel lasts 10 master cycles. `h1` is high for phases 0-4 and `h2` is high for phases 5-9. The two are never equal after reset.
- R3: Line length in pixels follows `ccd_sel`: 0→172, 1→2472, 2→2872, 3→6372, 4→8572, 5→14972, 6 and 7→172.
- R4: `bin_sel` sets the group size G = 10·B master cycles, with B = 1 for code 0 or 3, B = 2 for code 1 and B = 4 for code 2. Groups restart at every line start. `fd_rst` pulses exactly once per group.
- R5: Let g be the cycle index within a group. `fd_rst` is high at g = 0, `clamp` at g = 1..2 and `sample` at g = G-4..G-1. These three never overlap.
- R6: `adc_clk` is high for g < G/2. `pix_sync` is a single-cycle pulse at g = G/2.
- R7: `line_start` is high for one cycle at pixel 0, phase 0. `line_sync` is high while the pixel index is 26 or more.
- R8: On a transfer line, `tg1` is high for pixels 0-20, `tg2` for pixels 0-25 and `frame_sync` for pixel 0. On other lines all three stay low.
- R9: Transfer lines repeat every `integ_sel`+1 lines. A line counter advances at each line end and wraps to 0 when it reaches or exceeds the newly captured `integ_sel`. Counter value 0 marks a transfer line.
- R10: An exposure gate is high while pixel index < min(sel,14)·500. A setting of 0 keeps it low. Settings of 14 and 15 both give 7000.
- R11: `exp_red` drives only `exp_gate_red`, and `exp_grn` drives only `exp_gate_grn`.
- R12: Mode inputs are captured only while `rst` is high or on the cycle that ends a line. Changes made mid-line have no effect on the current line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| ccd_sel | input | 3 | Line-length code |
| bin_sel | input | 2 | Binning code |
| integ_sel | input | 2 | Integration multiple minus one |
| exp_red | input | 4 | Red exposure steps of 500 pixels |
| exp_grn | input | 4 | Green exposure steps of 500 pixels |
| h1 | output | 1 | Horizontal shift clock phase 1 |
| h2 | output | 1 | Horizontal shift clock phase 2 |
| fd_rst | output | 1 | Output-node reset pulse |
| clamp | output | 1 | Reset-level clamp strobe |
| sample | output | 1 | Signal-level sample strobe |
| adc_clk | output | 1 | Converter clock |
| pix_sync | output | 1 | Pixel-valid strobe |
| line_start | output | 1 | Line start marker |
| line_sync | output | 1 | Video region flag |
| frame_sync | output | 1 | Transfer-line marker |
| tg1 | output | 1 | Transfer gate 1 |
| tg2 | output | 1 | Transfer gate 2 |
| exp_gate_red | output | 1 | Red exposure gate |
| exp_gate_grn | output | 1 | Green exposure gate |

## Verification
On every cycle the assertions check several fixed relationships. The shift clocks are complementary and the three sampling strobes are mutually exclusive. The transfer gates nest as expected, and the video flag and transfer gates never overlap. The pixel counter stays below the line length, captured modes change only at a line end, and a zero exposure setting holds its gate low. Other behaviour is visible only to the bench's per-cycle reference model and its scenarios:

- the actual line lengths from the table;
- the group count per line under each binning setting;
- the spacing of transfer lines for each integration multiple;
- the 7000-pixel exposure cap;
- whether a mid-line change to the mode inputs leaves the running line intact.

// File: rtl/ccd_tg_pkg.sv
package ccd_tg_pkg;

  typedef struct packed {
    logic [2:0] ccd;
    logic [1:0] bin;
    logic [1:0] integ;
    logic [3:0] exp_r;
    logic [3:0] exp_g;
  } mode_t;

  // pixels per line for each line-length code
  function automatic int unsigned line_pixels(input logic [2:0] code);
    case (code)
      3'd1:    return 2472;
      3'd2:    return 2872;
      3'd3:    return 6372;
      3'd4:    return 8572;
      3'd5:    return 14972;
      default: return 172;
    endcase
  endfunction

  // pixels per readout group for each binning code
  function automatic int unsigned bin_span(input logic [1:0] code);
    case (code)
      2'd1:    return 2;
      2'd2:    return 4;
      default: return 1;
    endcase
  endfunction

endpackage

// File: rtl/ccd_pix_phase.sv
module ccd_pix_phase #(
  parameter int PIX_DIV = 10,
  parameter int MAX_BIN = 4,
  localparam int PH_W  = $clog2(PIX_DIV),
  localparam int GRP_W = $clog2(PIX_DIV * MAX_BIN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_wrap,
  input  logic [GRP_W-1:0] grp_last,
  output logic [PH_W-1:0]  phase,
  output logic [GRP_W-1:0] grp,
  output logic             pix_end
);

  assign pix_end = (phase == PH_W'(PIX_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
      grp   <= '0;
    end else begin
      phase <= pix_end ? '0 : phase + 1'b1;
      if (line_wrap || grp == grp_last) grp <= '0;
      else                              grp <= grp + 1'b1;
    end
  end

  // R2
  phase_range_chk: assert property (@(posedge clk) disable iff (rst)
    phase < PH_W'(PIX_DIV));

  // R4
  grp_align_chk: assert property (@(posedge clk) disable iff (rst)
    (grp == '0) |-> (phase == '0));

endmodule

// File: rtl/ccd_line_seq.sv
module ccd_line_seq import ccd_tg_pkg::*; #(
  parameter int PIX_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pix_end,
  input  mode_t            mode_in,
  output mode_t            mode_q,
  output logic [PIX_W-1:0] pix_cnt,
  output logic             xfer_line,
  output logic             line_wrap
);

  logic [PIX_W-1:0] len;
  logic [1:0]       icnt;

  assign len       = PIX_W'(line_pixels(mode_q.ccd));
  assign line_wrap = pix_end && (pix_cnt == len - 1'b1);
  assign xfer_line = (icnt == 2'd0);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= mode_in;
      pix_cnt <= '0;
      icnt    <= '0;
    end else if (pix_end) begin
      if (line_wrap) begin
        pix_cnt <= '0;
        mode_q  <= mode_in;
        icnt    <= (icnt >= mode_in.integ) ? 2'd0 : icnt + 2'd1;
      end else begin
        pix_cnt <= pix_cnt + 1'b1;
      end
    end
  end

  // R3
  pix_bound_chk: assert property (@(posedge clk) disable iff (rst)
    pix_cnt < len);

  // R12
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !line_wrap |=> $stable(mode_q));

  // R9
  icnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    icnt <= mode_q.integ);

endmodule

// File: rtl/ccd_exp_gate.sv
module ccd_exp_gate #(
  parameter int PIX_W     = 15,
  parameter int STEP      = 500,
  parameter int MAX_STEPS = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       sel,
  input  logic [PIX_W-1:0] pix_cnt,
  output logic             gate
);

  int unsigned steps;
  int unsigned limit;

  assign steps = (int'(sel) > MAX_STEPS) ? MAX_STEPS : int'(sel);
  assign limit = steps * STEP;

  always_ff @(posedge clk) begin
    if (rst) gate <= 1'b0;
    else     gate <= (int'(pix_cnt) < limit);
  end

  // R10
  zero_sel_chk: assert property (@(posedge clk) disable iff (rst)
    (sel == 4'd0) |=> !gate);

endmodule

// File: rtl/ccd_line_timer.sv
module ccd_line_timer import ccd_tg_pkg::*; #(
  parameter int PIX_DIV  = 10,
  parameter int MAX_BIN  = 4,
  parameter int PIX_W    = 15,
  parameter int TG1_PIX  = 21,
  parameter int TG2_PIX  = 26,
  parameter int CLAMP_W  = 2,
  parameter int SAMPLE_W = 4,
  parameter int EXP_STEP = 500,
  parameter int EXP_MAX  = 14
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] ccd_sel,
  input  logic [1:0] bin_sel,
  input  logic [1:0] integ_sel,
  input  logic [3:0] exp_red,
  input  logic [3:0] exp_grn,
  output logic       h1,
  output logic       h2,
  output logic       fd_rst,
  output logic       clamp,
  output logic       sample,
  output logic       adc_clk,
  output logic       pix_sync,
  output logic       line_start,
  output logic       line_sync,
  output logic       frame_sync,
  output logic       tg1,
  output logic       tg2,
  output logic       exp_gate_red,
  output logic       exp_gate_grn
);

  localparam int PH_W    = $clog2(PIX_DIV);
  localparam int GRP_W   = $clog2(PIX_DIV * MAX_BIN);
  localparam int N_COLOR = 2;

  mode_t            mode_in, mode_q;
  logic [PH_W-1:0]  phase;
  logic [GRP_W-1:0] grp, grp_last, grp_half, samp_from;
  logic [PIX_W-1:0] pix_cnt;
  logic             pix_end, line_wrap, xfer_line, run_q;
  logic [3:0]       exp_sel [N_COLOR];
  logic [N_COLOR-1:0] exp_gate;

  assign mode_in = '{ccd: ccd_sel, bin: bin_sel, integ: integ_sel,
                     exp_r: exp_red, exp_g: exp_grn};

  assign grp_last  = GRP_W'(PIX_DIV * int'(bin_span(mode_q.bin)) - 1);
  assign grp_half  = GRP_W'(PIX_DIV * int'(bin_span(mode_q.bin)) / 2);
  assign samp_from = grp_last - GRP_W'(SAMPLE_W - 1);

  ccd_pix_phase #(.PIX_DIV(PIX_DIV), .MAX_BIN(MAX_BIN)) u_phase (
    .clk(clk), .rst(rst), .line_wrap(line_wrap), .grp_last(grp_last),
    .phase(phase), .grp(grp), .pix_end(pix_end));

  ccd_line_seq #(.PIX_W(PIX_W)) u_seq (
    .clk(clk), .rst(rst), .pix_end(pix_end), .mode_in(mode_in),
    .mode_q(mode_q), .pix_cnt(pix_cnt), .xfer_line(xfer_line),
    .line_wrap(line_wrap));

  assign exp_sel[0] = mode_q.exp_r;
  assign exp_sel[1] = mode_q.exp_g;

  for (genvar c = 0; c < N_COLOR; c++) begin : g_exp
    ccd_exp_gate #(.PIX_W(PIX_W), .STEP(EXP_STEP), .MAX_STEPS(EXP_MAX)) u_gate (
      .clk(clk), .rst(rst), .sel(exp_sel[c]), .pix_cnt(pix_cnt),
      .gate(exp_gate[c]));
  end

  assign exp_gate_red = exp_gate[0];
  assign exp_gate_grn = exp_gate[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q      <= 1'b0;
      h1         <= 1'b0;
      h2         <= 1'b0;
      fd_rst     <= 1'b0;
      clamp      <= 1'b0;
      sample     <= 1'b0;
      adc_clk    <= 1'b0;
      pix_sync   <= 1'b0;
      line_start <= 1'b0;
      line_sync  <= 1'b0;
      frame_sync <= 1'b0;
      tg1        <= 1'b0;
      tg2        <= 1'b0;
    end else begin
      run_q      <= 1'b1;
      h1         <= (phase <  PH_W'(PIX_DIV / 2));
      h2         <= (phase >= PH_W'(PIX_DIV / 2));
      fd_rst     <= (grp == '0);
      clamp      <= (grp >= GRP_W'(1)) && (grp <= GRP_W'(CLAMP_W));
      sample     <= (grp >= samp_from);
      adc_clk    <= (grp <  grp_half);
      pix_sync   <= (grp == grp_half);
      line_start <= (pix_cnt == '0) && (phase == '0);
      line_sync  <= (pix_cnt >= PIX_W'(TG2_PIX));
      frame_sync <= xfer_line && (pix_cnt == '0);
      tg1        <= xfer_line && (pix_cnt < PIX_W'(TG1_PIX));
      tg2        <= xfer_line && (pix_cnt < PIX_W'(TG2_PIX));
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> ({h1, h2, fd_rst, clamp, sample, adc_clk, pix_sync, line_start,
              line_sync, frame_sync, tg1, tg2, exp_gate_red, exp_gate_grn} == '0));

  // R2
  h_comp_chk: assert property (@(posedge clk) disable iff (rst)
    run_q |-> (h1 != h2));

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $countones({fd_rst, clamp, sample}) <= 1);

  // R6
  pix_adc_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pix_sync) |-> !adc_clk);

  // R7
  start_reset_chk: assert property (@(posedge clk) disable iff (rst)
    line_start |-> fd_rst);

  // R7
  video_notg_chk: assert property (@(posedge clk) disable iff (rst)
    line_sync |-> !tg2);

  // R8
  tg_nest_chk: assert property (@(posedge clk) disable iff (rst)
    tg1 |-> tg2);

  // R8
  frame_tg_chk: assert property (@(posedge clk) disable iff (rst)
    frame_sync |-> tg1);

endmodule

// File: tb/sim_ccd_line_timer.sv
`timescale 1ns/1ps
module sim_ccd_line_timer;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] ccd_sel = 3'd0;
  logic [1:0] bin_sel = 2'd0;
  logic [1:0] integ_sel = 2'd0;
  logic [3:0] exp_red = 4'd0;
  logic [3:0] exp_grn = 4'd1;
  logic h1, h2, fd_rst, clamp, sample, adc_clk, pix_sync, line_start;
  logic line_sync, frame_sync, tg1, tg2, exp_gate_red, exp_gate_grn;

  always #2 clk = ~clk;

  ccd_line_timer u0 (
    .clk(clk), .rst(rst), .ccd_sel(ccd_sel), .bin_sel(bin_sel),
    .integ_sel(integ_sel), .exp_red(exp_red), .exp_grn(exp_grn),
    .h1(h1), .h2(h2), .fd_rst(fd_rst), .clamp(clamp), .sample(sample),
    .adc_clk(adc_clk), .pix_sync(pix_sync), .line_start(line_start),
    .line_sync(line_sync), .frame_sync(frame_sync), .tg1(tg1), .tg2(tg2),
    .exp_gate_red(exp_gate_red), .exp_gate_grn(exp_gate_grn));

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  string nm  [14] = '{"exp_gate_grn","exp_gate_red","tg2","tg1","frame_sync",
                      "line_sync","line_start","pix_sync","adc_clk","sample",
                      "clamp","fd_rst","h2","h1"};
  string tag [14] = '{"R11","R10","R8/R9","R8/R9","R8/R9","R7","R7","R6",
                      "R6/R4","R5","R5","R5/R4","R2","R2"};

  // ---------------- reference model ----------------
  int m_ccd, m_bin, m_int, m_er, m_eg;
  int mc, pc, ic;
  bit primed = 0;
  bit in_rst = 0;
  logic [13:0] exp_v = '0;

  function automatic int len_of(int code);
    case (code)
      1: return 2472; 2: return 2872; 3: return 6372;
      4: return 8572; 5: return 14972; default: return 172;
    endcase
  endfunction

  function automatic int span_of(int code);
    return (code == 1) ? 2 : (code == 2) ? 4 : 1;
  endfunction

  function automatic int cap(int s);
    return (s > 14) ? 14 : s;
  endfunction

  always @(posedge clk) begin
    primed = 1;
    if (rst) begin
      in_rst = 1;
      exp_v = '0;
      mc = 0; pc = 0; ic = 0;
      m_ccd = ccd_sel; m_bin = bin_sel; m_int = integ_sel;
      m_er = exp_red; m_eg = exp_grn;
    end else begin
      int b, gs, g;
      bit xf;
      in_rst = 0;
      b  = span_of(m_bin);
      gs = 10 * b;
      g  = (pc % b) * 10 + mc;
      xf = (ic == 0);
      exp_v[13] = (mc < 5);
      exp_v[12] = (mc >= 5);
      exp_v[11] = (g == 0);
      exp_v[10] = (g >= 1 && g <= 2);
      exp_v[9]  = (g >= gs - 4);
      exp_v[8]  = (g < gs / 2);
      exp_v[7]  = (g == gs / 2);
      exp_v[6]  = (pc == 0 && mc == 0);
      exp_v[5]  = (pc >= 26);
      exp_v[4]  = xf && pc == 0;
      exp_v[3]  = xf && pc < 21;
      exp_v[2]  = xf && pc < 26;
      exp_v[1]  = (pc < cap(m_er) * 500);
      exp_v[0]  = (pc < cap(m_eg) * 500);
      mc++;
      if (mc == 10) begin
        mc = 0;
        pc++;
        if (pc == len_of(m_ccd)) begin
          pc = 0;
          if (ic >= int'(integ_sel)) ic = 0; else ic++;
          m_ccd = ccd_sel; m_bin = bin_sel; m_int = integ_sel;
          m_er = exp_red; m_eg = exp_grn;
        end
      end
    end
  end

  // ---------------- per-cycle comparison and measurement ----------------
  int cyc = 0, last_ls = -1, period = 0, fd_cur = 0, fd_last = 0;
  bit ls_prev = 0;

  always @(negedge clk) begin
    if (primed && !done) begin
      logic [13:0] act_v;
      act_v = {h1, h2, fd_rst, clamp, sample, adc_clk, pix_sync, line_start,
               line_sync, frame_sync, tg1, tg2, exp_gate_red, exp_gate_grn};
      for (int i = 0; i < 14; i++) begin
        n_chk++;
        if (act_v[i] !== exp_v[i]) begin
          n_bad++;
          $display("FAIL %s %s cyc=%0d actual=%b expected=%b",
                   in_rst ? "R1" : tag[i], nm[i], cyc, act_v[i], exp_v[i]);
        end
      end
      cyc++;
      if (line_start && !ls_prev) begin
        if (last_ls >= 0) period = cyc - last_ls;
        last_ls = cyc;
        fd_last = fd_cur;
        fd_cur  = fd_rst ? 1 : 0;
      end else if (fd_rst) begin
        fd_cur++;
      end
      ls_prev = line_start;
    end
  end

  task automatic check_int(string req, string what, int act, int expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic wait_lines(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge line_start);
      @(negedge clk);
      #1;
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // A: 172-pixel lines, no binning, 1X, red exposure 0, green 1 step
    wait_lines(3);
    check_int("R3", "line period 172 px", period, 1720);
    check_int("R4", "reset pulses per line, no binning", fd_last, 172);

    // B: binning 2, integration 2X; a mid-line change to the length code
    bin_sel = 2'd1; integ_sel = 2'd1;
    wait_lines(2);
    repeat (300) @(negedge clk);
    ccd_sel = 3'd1;
    repeat (300) @(negedge clk);
    ccd_sel = 3'd0;
    wait_lines(1);
    check_int("R12", "line period after mid-line code toggle", period, 1720);
    check_int("R4", "reset pulses per line, bin 2", fd_last, 86);
    wait_lines(2);

    // C: binning 4, integration 4X, exposures swapped
    bin_sel = 2'd2; integ_sel = 2'd3; exp_red = 4'd1; exp_grn = 4'd0;
    wait_lines(6);
    check_int("R4", "reset pulses per line, bin 4", fd_last, 43);

    // D: 2472-pixel line, partial red exposure, green over full line
    ccd_sel = 3'd1; bin_sel = 2'd0; integ_sel = 2'd0;
    exp_red = 4'd3; exp_grn = 4'd5;
    wait_lines(1);
    repeat (1000) @(negedge clk);
    // E: 8572-pixel line, both exposures at the cap
    ccd_sel = 3'd4; exp_red = 4'd15; exp_grn = 4'd14;
    wait_lines(1);
    check_int("R3", "line period 2472 px", period, 24720);
    wait_lines(1);
    check_int("R3", "line period 8572 px", period, 85720);
    check_int("R10", "exposure cap reached on long line", period > 70000 ? 1 : 0, 1);

    finish_run();
  end

endmodule